// File: doc/BRIEF.md
# Remote-Sharing Signature Counter Array

This block builds a per-thread signature of remote data sharing. Each sample event carries a data address, a thread number and a flag that is set when the access was served from another chip. The address is reduced to a 128-byte region number, the size of one coherence granule. That region number is folded down to an 8-bit entry index. The block keeps a separate vector of 256 saturating 8-bit counters for every thread, and an admitted remote sample bumps the entry of its thread.

Aliasing in the small vector is held down by a spatial filter. A region only counts once it sits in a 32-entry fully associative table of admitted region numbers. A region that misses the table is offered admission on that remote access, and whether it gets in depends on a pseudo-random LFSR. When it does get in, it takes the next slot in round-robin order. That first access is not counted. Later remote accesses to the region are.

Software reads any counter through a registered read port. It can also wipe one thread's vector with a clear command, which sweeps that thread's 256 entries, one per cycle.

Top module: `sharing_map`

## Requirements
- R1: After reset, every counter reads 0, the admitted-region table is empty, busy is 0 and the LFSR holds 16'hACE1.
- R2: A counter that holds 255 stays at 255 when it is incremented. Counters never wrap.
- R3: A sample with smp_remote=0 changes no counter, no table entry and no LFSR state.
- R4: The region number is smp_addr[31:7], with bits [6:0] dropped. The entry index XORs bit i of the region into index bit (i mod 8). Same-index regions share one counter.
- R5: A remote sample whose region is in the table increments counter [smp_thread][index] by one at the next clock edge.
- R6: A remote sample whose region misses the table never counts. It steps the LFSR, where next = {l[14:0], l[15]^l[13]^l[12]^l[10]}. The region is written into the table only when bit 0 of the LFSR value before the step is 0.
- R7: Table writes go to slots 0,1,...,31 and then wrap back to 0, so the 33rd admission overwrites the 1st. After that a sample of the overwritten region misses the table.
- R8: rd_data shows counter [rd_thread][rd_idx] one cycle after the request. If an increment hits that same entry in the request cycle, rd_data shows the value from before the increment.
- R9: clr_req while busy=0 raises busy on the next cycle for exactly 256 cycles, and all counters of clr_thread read 0 afterwards. Other threads' counters are kept.
- R10: While busy is high, samples whose thread equals the thread being cleared are dropped completely. Samples for other threads are processed normally, and clr_req is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| smp_valid | input | 1 | Sample event present this cycle |
| smp_addr | input | 32 | Sampled data address |
| smp_thread | input | 1 | Thread that issued the access |
| smp_remote | input | 1 | Access was served from another chip |
| clr_req | input | 1 | Start clearing one thread's counters |
| clr_thread | input | 1 | Thread to clear |
| busy | output | 1 | Clear sweep in progress |
| rd_thread | input | 1 | Thread selected for reading |
| rd_idx | input | 8 | Counter index selected for reading |
| rd_data | output | 8 | Registered counter value |

## Verification
Counter state can only be seen through the read port. A wrong increment, a missed saturation or a bad clear therefore shows up in rd_data one cycle after a read of the affected entry.

Errors in the filter stay hidden for longer. A wrong LFSR step or a wrong table slot only shows later, when some region counts that should not, or fails to count when it should, on its next remote access. For that reason the bench carries its own model of the table and the LFSR and reads back after every sample. The model and the round-robin test together cover an eviction going to the wrong slot, which only appears 32 admissions later.

// File: rtl/sm_pkg.sv
package sm_pkg;
    localparam int LFSR_W = 16;
    localparam logic [LFSR_W-1:0] LFSR_SEED = 16'hACE1;

    typedef enum logic {CLR_IDLE, CLR_RUN} clr_state_e;

    // Fibonacci step, taps 16,14,13,11
    function automatic logic [LFSR_W-1:0] lfsr_step(input logic [LFSR_W-1:0] l);
        return {l[LFSR_W-2:0], l[15] ^ l[13] ^ l[12] ^ l[10]};
    endfunction
endpackage

// File: rtl/sm_region_filter.sv
module sm_region_filter #(
    parameter int REG_W    = 25,
    parameter int TAGS     = 32,
    parameter int SEL_BITS = 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             valid,
    input  logic             remote,
    input  logic [REG_W-1:0] region,
    output logic             inc_en,
    output logic             ins_en
);
    import sm_pkg::*;
    localparam int PTR_W = $clog2(TAGS);

    logic [REG_W-1:0]  tag_q [TAGS];
    logic [TAGS-1:0]   vld_q;
    logic [PTR_W-1:0]  ptr_q;
    logic [LFSR_W-1:0] lfsr_q;
    logic              hit;
    logic              miss_ev;

    always_comb begin
        hit = 1'b0;
        for (int i = 0; i < TAGS; i++)
            if (vld_q[i] && tag_q[i] == region) hit = 1'b1;
    end

    assign miss_ev = valid && remote && !hit;
    assign inc_en  = valid && remote && hit;
    assign ins_en  = miss_ev && (lfsr_q[SEL_BITS-1:0] == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            vld_q  <= '0;
            ptr_q  <= '0;
            lfsr_q <= LFSR_SEED;
            for (int i = 0; i < TAGS; i++) tag_q[i] <= '0;
        end else begin
            if (miss_ev) lfsr_q <= lfsr_step(lfsr_q);
            if (ins_en) begin
                tag_q[ptr_q] <= region;
                vld_q[ptr_q] <= 1'b1;
                ptr_q <= (ptr_q == PTR_W'(TAGS - 1)) ? '0 : ptr_q + 1'b1;
            end
        end
    end
endmodule

// File: rtl/sm_counter_bank.sv
module sm_counter_bank #(
    parameter int NUM_THREADS = 2,
    parameter int IDX_W       = 8,
    parameter int CNT_W       = 8,
    parameter int TID_W       = 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             inc_en,
    input  logic [TID_W-1:0] inc_tid,
    input  logic [IDX_W-1:0] inc_idx,
    input  logic             clr_req,
    input  logic [TID_W-1:0] clr_thread,
    output logic             busy,
    output logic [TID_W-1:0] clr_tid,
    input  logic [TID_W-1:0] rd_thread,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [CNT_W-1:0] rd_data
);
    import sm_pkg::*;
    localparam int ENTRIES = 1 << IDX_W;
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic [CNT_W-1:0] cnt_q [NUM_THREADS][ENTRIES];
    clr_state_e       st_q;
    logic [IDX_W-1:0] cidx_q;

    assign busy = (st_q == CLR_RUN);

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q    <= CLR_IDLE;
            cidx_q  <= '0;
            clr_tid <= '0;
        end else if (st_q == CLR_IDLE) begin
            if (clr_req) begin
                st_q    <= CLR_RUN;
                cidx_q  <= '0;
                clr_tid <= clr_thread;
            end
        end else begin
            cidx_q <= cidx_q + 1'b1;
            if (cidx_q == IDX_W'(ENTRIES - 1)) st_q <= CLR_IDLE;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_data <= '0;
            for (int t = 0; t < NUM_THREADS; t++)
                for (int e = 0; e < ENTRIES; e++) cnt_q[t][e] <= '0;
        end else begin
            rd_data <= cnt_q[rd_thread][rd_idx];
            if (inc_en && cnt_q[inc_tid][inc_idx] != CNT_MAX)
                cnt_q[inc_tid][inc_idx] <= cnt_q[inc_tid][inc_idx] + 1'b1;
            if (busy) cnt_q[clr_tid][cidx_q] <= '0;
        end
    end
endmodule

// File: rtl/sharing_map.sv
module sharing_map #(
    parameter int NUM_THREADS = 2,
    parameter int ADDR_W      = 32,
    parameter int GRAN_W      = 7,
    parameter int IDX_W       = 8,
    parameter int CNT_W       = 8,
    parameter int TAGS        = 32,
    parameter int SEL_BITS    = 1,
    localparam int TID_W      = $clog2(NUM_THREADS),
    localparam int REG_W      = ADDR_W - GRAN_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              smp_valid,
    input  logic [ADDR_W-1:0] smp_addr,
    input  logic [TID_W-1:0]  smp_thread,
    input  logic              smp_remote,
    input  logic              clr_req,
    input  logic [TID_W-1:0]  clr_thread,
    output logic              busy,
    input  logic [TID_W-1:0]  rd_thread,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [CNT_W-1:0]  rd_data
);
    localparam int ENTRIES = 1 << IDX_W;

    logic [REG_W-1:0] region;
    logic [IDX_W-1:0] hidx;
    logic [TID_W-1:0] clr_tid_q;
    logic             smp_ok;
    logic             inc_en;
    logic             ins_en;

    assign region = smp_addr[ADDR_W-1:GRAN_W];

    always_comb begin
        hidx = '0;
        for (int i = 0; i < REG_W; i++)
            hidx[i % IDX_W] = hidx[i % IDX_W] ^ region[i];
    end

    assign smp_ok = smp_valid && !(busy && smp_thread == clr_tid_q);

    sm_region_filter #(.REG_W(REG_W), .TAGS(TAGS), .SEL_BITS(SEL_BITS)) u_filt (
        .clk(clk), .rst(rst), .valid(smp_ok), .remote(smp_remote),
        .region(region), .inc_en(inc_en), .ins_en(ins_en)
    );

    sm_counter_bank #(.NUM_THREADS(NUM_THREADS), .IDX_W(IDX_W), .CNT_W(CNT_W),
                      .TID_W(TID_W)) u_bank (
        .clk(clk), .rst(rst), .inc_en(inc_en), .inc_tid(smp_thread),
        .inc_idx(hidx), .clr_req(clr_req), .clr_thread(clr_thread),
        .busy(busy), .clr_tid(clr_tid_q), .rd_thread(rd_thread),
        .rd_idx(rd_idx), .rd_data(rd_data)
    );
endmodule

// File: rtl/sm_checker.sv
module sm_checker #(
    parameter int TID_W   = 1,
    parameter int ENTRIES = 256
) (
    input logic             clk,
    input logic             rst,
    input logic             smp_valid,
    input logic             smp_remote,
    input logic [TID_W-1:0] smp_thread,
    input logic             busy,
    input logic [TID_W-1:0] clr_tid_q,
    input logic             inc_en,
    input logic             ins_en
);
    logic [15:0] busy_cyc;
    always_ff @(posedge clk) begin
        if (rst) busy_cyc <= '0;
        else if (busy) busy_cyc <= busy_cyc + 1'b1;
        else busy_cyc <= '0;
    end

    a_r1_idle_after_reset: assert property (@(posedge clk)
        $past(rst) |-> !busy);
    a_r3_local_no_inc: assert property (@(posedge clk) disable iff (rst)
        !(smp_valid && smp_remote) |-> !(inc_en || ins_en));
    a_r6_admit_not_counted: assert property (@(posedge clk) disable iff (rst)
        ins_en |-> !inc_en);
    a_r9_sweep_length: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> busy_cyc == 16'(ENTRIES));
    a_r10_cleared_thread_dropped: assert property (@(posedge clk) disable iff (rst)
        (busy && smp_thread == clr_tid_q) |-> !(inc_en || ins_en));
endmodule

bind sharing_map sm_checker #(.TID_W(TID_W), .ENTRIES(ENTRIES)) u_chk (
    .clk(clk), .rst(rst), .smp_valid(smp_valid), .smp_remote(smp_remote),
    .smp_thread(smp_thread), .busy(busy), .clr_tid_q(clr_tid_q),
    .inc_en(inc_en), .ins_en(ins_en)
);

// File: tb/tb_sharing_map.sv
`timescale 1ns/1ps
module tb_sharing_map;
    logic        clk = 0;
    logic        rst = 1;
    logic        smp_valid = 0;
    logic [31:0] smp_addr = 0;
    logic        smp_thread = 0;
    logic        smp_remote = 0;
    logic        clr_req = 0;
    logic        clr_thread = 0;
    logic        busy;
    logic        rd_thread = 0;
    logic [7:0]  rd_idx = 0;
    logic [7:0]  rd_data;

    int errors = 0;
    int checks = 0;
    bit done = 0;

    always #10 clk = ~clk;

    sharing_map dut (.*);

    // independent model
    logic [24:0] m_tag [32];
    bit          m_vld [32];
    int          m_ptr;
    logic [15:0] m_lfsr;
    int          m_cnt [2][256];

    function automatic logic [7:0] h_of(input logic [31:0] a);
        logic [31:0] r;
        r = {7'd0, a[31:7]};
        return r[7:0] ^ r[15:8] ^ r[23:16] ^ r[31:24];
    endfunction

    task automatic model(input logic [31:0] a, input bit t, input bit rem, output bit adm);
        bit hit;
        logic [24:0] rg;
        adm = 0;
        if (!rem) return;
        rg = a[31:7];
        hit = 0;
        for (int i = 0; i < 32; i++) if (m_vld[i] && m_tag[i] == rg) hit = 1;
        if (hit) begin
            if (m_cnt[t][h_of(a)] < 255) m_cnt[t][h_of(a)]++;
        end else begin
            if (m_lfsr[0] == 1'b0) begin
                m_tag[m_ptr] = rg; m_vld[m_ptr] = 1; m_ptr = (m_ptr + 1) % 32; adm = 1;
            end
            m_lfsr = {m_lfsr[14:0], m_lfsr[15]^m_lfsr[13]^m_lfsr[12]^m_lfsr[10]};
        end
    endtask

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic sample(input logic [31:0] a, input bit t, input bit rem, output bit adm);
        @(negedge clk);
        smp_valid = 1; smp_addr = a; smp_thread = t; smp_remote = rem;
        @(posedge clk);
        model(a, t, rem, adm);
        @(negedge clk);
        smp_valid = 0;
    endtask

    task automatic rd_chk(input bit t, input logic [7:0] idx, input string req);
        @(negedge clk);
        rd_thread = t; rd_idx = idx;
        @(posedge clk);
        #1 check(req, rd_data, m_cnt[t][idx]);
    endtask

    // {addr, thread, remote}
    localparam logic [33:0] VEC [12] = '{
        {32'h0000_1000, 1'b0, 1'b1}, {32'h0000_1000, 1'b0, 1'b1},
        {32'h0000_1040, 1'b0, 1'b1}, {32'h0000_1000, 1'b1, 1'b1},
        {32'h0002_0080, 1'b1, 1'b1}, {32'h0002_0080, 1'b1, 1'b1},
        {32'h0000_1000, 1'b0, 1'b0}, {32'h0002_0080, 1'b0, 1'b1},
        {32'h0001_0100, 1'b0, 1'b1}, {32'h0100_0100, 1'b0, 1'b1},
        {32'h0001_0100, 1'b0, 1'b1}, {32'h0100_0100, 1'b1, 1'b1}};

    initial begin
        #(20ns * 200000);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        bit adm;
        logic [31:0] a_sat, b_last;
        int bcnt, guard, keep;
        m_ptr = 0; m_lfsr = 16'hACE1;
        for (int i = 0; i < 32; i++) begin m_vld[i] = 0; m_tag[i] = '0; end
        for (int t = 0; t < 2; t++) for (int e = 0; e < 256; e++) m_cnt[t][e] = 0;
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 0;

        // R1 reset state
        check("R1 busy", busy, 0);
        rd_chk(0, 8'd0, "R1 counter");
        rd_chk(1, 8'd255, "R1 counter");

        // R4 R5 R6 vector walk (index fold, counting, admission)
        for (int v = 0; v < 12; v++) begin
            sample(VEC[v][33:2], VEC[v][1], VEC[v][0], adm);
            rd_chk(VEC[v][1], h_of(VEC[v][33:2]), "R5 vector");
        end

        // R3 local access has no effect
        keep = m_cnt[0][h_of(32'h0000_1000)];
        sample(32'h0000_1000, 0, 0, adm);
        rd_chk(0, h_of(32'h0000_1000), "R3 local");
        check("R3 local unchanged", m_cnt[0][h_of(32'h0000_1000)], keep);

        // R2 saturation
        a_sat = 32'h0004_0000;
        guard = 0;
        while (m_cnt[1][h_of(a_sat)] < 255 && guard < 2000) begin
            sample(a_sat, 1, 1, adm); guard++;
        end
        repeat (4) sample(a_sat, 1, 1, adm);
        rd_chk(1, h_of(a_sat), "R2 saturate");
        check("R2 reached 255", m_cnt[1][h_of(a_sat)], 255);

        // R7 round-robin overwrite of a_sat's slot
        b_last = 0;
        for (int k = 0; k < 32; k++) begin
            logic [31:0] a;
            a = 32'h0800_0000 + k * 32'h80;
            guard = 0;
            adm = 0;
            while (!adm && guard < 200) begin sample(a, 0, 1, adm); guard++; end
            b_last = a;
        end
        keep = m_cnt[1][h_of(a_sat)];
        sample(a_sat, 1, 1, adm);
        rd_chk(1, h_of(a_sat), "R7 evicted");
        check("R7 evicted no count", m_cnt[1][h_of(a_sat)], keep);

        // R8 read and increment of the same entry in one cycle
        keep = m_cnt[0][h_of(b_last)];
        @(negedge clk);
        smp_valid = 1; smp_addr = b_last; smp_thread = 0; smp_remote = 1;
        rd_thread = 0; rd_idx = h_of(b_last);
        @(posedge clk);
        model(b_last, 0, 1, adm);
        #1 check("R8 pre-increment", rd_data, keep);
        @(negedge clk); smp_valid = 0;
        rd_chk(0, h_of(b_last), "R8 after");

        // R9 R10 clear of thread 1
        @(negedge clk); clr_req = 1; clr_thread = 1;
        @(negedge clk); clr_req = 0;
        bcnt = 0;
        for (int i = 0; i < 300; i++) begin
            if (busy) bcnt++;
            smp_valid = 0;
            if (i == 5) begin
                smp_valid = 1; smp_addr = b_last; smp_thread = 1; smp_remote = 1;
            end
            if (i == 6) begin
                smp_valid = 1; smp_addr = b_last; smp_thread = 0; smp_remote = 1;
            end
            if (i == 7) begin
                clr_req = 1; clr_thread = 0;
            end
            @(posedge clk);
            if (i == 6) model(b_last, 0, 1, adm);
            @(negedge clk);
            smp_valid = 0; clr_req = 0;
        end
        check("R9 busy length", bcnt, 256);
        check("R9 busy low", busy, 0);
        for (int e = 0; e < 256; e++) m_cnt[1][e] = 0;
        rd_chk(1, h_of(a_sat), "R9 cleared");
        rd_chk(1, h_of(b_last), "R10 dropped");
        rd_chk(0, h_of(b_last), "R10 other thread counted");
        rd_chk(0, h_of(32'h0000_1000), "R10 clr_req ignored while busy");

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule